// File: doc/BRIEF.md
# Reset Boot Source Selector

This block chooses where instruction fetch begins once reset is released: at the entry point of the on-chip boot ROM, or at the entry point of user flash program memory. The normal choice comes from one configuration bit held in nonvolatile option storage. An erased bit (0) selects the boot ROM and a programmed bit (1) selects flash. The bit is captured only while reset is active, so a new value takes effect at the next external or software reset.

A recovery path allows firmware that has locked up to be replaced. An external comparator reports a high-voltage level on a dedicated pin. If that level is present while reset is active, and it is still present through the third instruction-cycle strobe after release, the boot ROM is selected whatever the configuration bit says. The raw detector output is synchronized with a two-stage flop chain. A strobe counter starts when reset is released. Fetch is held off (`fetch_en` low) until the counter has seen three strobes. At that point the boot choice is frozen until the next reset.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `boot_src_sel`

## Requirements
- R1: While a reset is active (`rst_n` low or `sw_rst` high), `fetch_en` is 0, `boot_rom_sel` is 0 and `fetch_addr` equals FLASH_ENTRY (default 16'h0000).
- R2: After reset release, `fetch_en` stays 0 until HOLD_CYC (default 3) clock edges have sampled `cyc_stb` high. It is 1 in the cycle after the edge that samples the last of those strobes.
- R3: With configuration bit 0 and no override, fetch is released with `boot_rom_sel` = 1 and `fetch_addr` = ROM_ENTRY (default 16'h8000).
- R4: With configuration bit 1 and no override, fetch is released with `boot_rom_sel` = 0 and `fetch_addr` = FLASH_ENTRY.
- R5: The override selects the boot ROM regardless of the configuration bit. For the override to count, the synchronized detector must be high on the last reset cycle and on every cycle up to and including the deciding strobe edge. The synchronizer is SYNC_STAGES (default 2) flops, so the raw pin must rise at least that many cycles before reset ends.
- R6: If the detector drops early enough that its synchronized value goes low before the deciding strobe edge, the configuration bit alone decides.
- R7: A detector level that first appears after reset release does not override the configuration bit.
- R8: The configuration bit is captured during reset. Changes to it after release have no effect until the next reset.
- R9: Once fetch is released, `fetch_en`, `boot_rom_sel` and `fetch_addr` hold their values until the next reset, whatever the detector, configuration bit or strobe do.
- R10: `sw_rst` acts like the external reset: it clears the decision, and on its release the capture and count sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, sampled synchronously |
| sw_rst | input | 1 | Software reset request, active high level |
| cyc_stb | input | 1 | Instruction-cycle strobe, one clock wide per cycle |
| cfg_flash_boot | input | 1 | Option configuration bit (1 selects flash) |
| hv_det | input | 1 | Raw high-voltage detector output (asynchronous) |
| fetch_en | output | 1 | Fetch may start |
| boot_rom_sel | output | 1 | 1 when the boot ROM is the fetch source |
| fetch_addr | output | ADDR_W | Starting fetch address in the unified map |

## Verification
The assertions check several properties on every cycle:
- the latched choice and address stay fixed while fetch is enabled;
- a software reset always clears the release and selection;
- fetch release only ever follows a sampled strobe;
- the strobe counter never passes its limit;
- the address always agrees with the select flag.

Other behaviours involve the relative timing of the detector, reset release and strobes, so only the bench scenarios can show them. These are:
- which source is chosen for each combination of configuration bit and detector history: held, dropped early, or raised late;
- the exact release cycle;
- that post-release changes to the configuration bit are ignored.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } boot_phase_e;

  // Boot ROM wins when the override survived or the option bit is erased.
  function automatic logic pick_rom(input logic cfg_flash, input logic ovr_alive);
    return ovr_alive | ~cfg_flash;
  endfunction

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  // The chain has no reset, so it keeps tracking the pin while reset is held.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bss_cyc_count.sv
module bss_cyc_count #(
  parameter int HOLD_CYC = 3,
  localparam int CNT_W = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic             stb,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  assign done = en & stb & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
    end else if (en && stb && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bss_decide.sv
module bss_decide
  import boot_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_any,
  input  logic        cfg_in,
  input  logic        hv_s,
  input  logic        done,
  output logic        rom_sel,
  output boot_phase_e phase
);
  logic cfg_q;
  logic ovr_ok;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      cfg_q   <= cfg_in;
      ovr_ok  <= hv_s;
      rom_sel <= 1'b0;
      phase   <= PH_HOLD;
    end else if (phase == PH_HOLD) begin
      ovr_ok <= ovr_ok & hv_s;
      if (done) begin
        rom_sel <= pick_rom(cfg_q, ovr_ok & hv_s);
        phase   <= PH_RUN;
      end
    end
  end
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
  import boot_sel_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          HOLD_CYC    = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] FLASH_ENTRY = 16'h0000,
  parameter logic [15:0] ROM_ENTRY   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              cyc_stb,
  input  logic              cfg_flash_boot,
  input  logic              hv_det,
  output logic              fetch_en,
  output logic              boot_rom_sel,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             rst_any;
  logic             hv_s;
  logic             done;
  logic [CNT_W-1:0] hold_cnt;
  boot_phase_e      phase;

  assign rst_any = ~rst_n | sw_rst;

  bss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (hv_det),
    .q_sync  (hv_s)
  );

  bss_cyc_count #(.HOLD_CYC(HOLD_CYC)) u_cnt (
    .clk  (clk),
    .clr  (rst_any),
    .en   (phase == PH_HOLD),
    .stb  (cyc_stb),
    .done (done),
    .cnt  (hold_cnt)
  );

  bss_decide u_dec (
    .clk     (clk),
    .rst_any (rst_any),
    .cfg_in  (cfg_flash_boot),
    .hv_s    (hv_s),
    .done    (done),
    .rom_sel (boot_rom_sel),
    .phase   (phase)
  );

  assign fetch_en   = (phase == PH_RUN);
  assign fetch_addr = boot_rom_sel ? ADDR_W'(ROM_ENTRY) : ADDR_W'(FLASH_ENTRY);
endmodule

// File: rtl/boot_src_sel_chk.sv
module boot_src_sel_chk #(
  parameter int          ADDR_W      = 16,
  parameter int          HOLD_CYC    = 3,
  parameter logic [15:0] FLASH_ENTRY = 16'h0000,
  parameter logic [15:0] ROM_ENTRY   = 16'h8000,
  localparam int CNT_W = $clog2(HOLD_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic              cyc_stb,
  input logic              fetch_en,
  input logic              boot_rom_sel,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [CNT_W-1:0]  hold_cnt
);
  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !sw_rst) |=> (fetch_en && $stable(boot_rom_sel) && $stable(fetch_addr)));

  // R10
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!fetch_en && !boot_rom_sel));

  // R2
  release_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_en) |-> $past(cyc_stb));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= CNT_W'(HOLD_CYC - 1));

  // R3
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr == (boot_rom_sel ? ADDR_W'(ROM_ENTRY) : ADDR_W'(FLASH_ENTRY)));
endmodule

bind boot_src_sel boot_src_sel_chk #(
  .ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC), .FLASH_ENTRY(FLASH_ENTRY), .ROM_ENTRY(ROM_ENTRY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cyc_stb(cyc_stb),
  .fetch_en(fetch_en), .boot_rom_sel(boot_rom_sel), .fetch_addr(fetch_addr),
  .hold_cnt(hold_cnt)
);

// File: tb/boot_src_sel_test.sv
`timescale 1ns/1ps
module boot_src_sel_test;
  localparam logic [15:0] FLASH_E = 16'h0000;
  localparam logic [15:0] ROM_E   = 16'h8000;
  localparam int MAX_CYC = 150000;

  localparam int M_NONE = 0;
  localparam int M_HELD = 1;
  localparam int M_DROP = 2;
  localparam int M_LATE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        cyc_stb = 1'b0;
  logic        cfg_flash_boot = 1'b0;
  logic        hv_det = 1'b0;
  logic        fetch_en;
  logic        boot_rom_sel;
  logic [15:0] fetch_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  boot_src_sel uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cyc_stb(cyc_stb),
    .cfg_flash_boot(cfg_flash_boot), .hv_det(hv_det),
    .fetch_en(fetch_en), .boot_rom_sel(boot_rom_sel), .fetch_addr(fetch_addr)
  );

  function automatic logic exp_rom(input logic cfg, input int mode);
    return (mode == M_HELD) | ~cfg;
  endfunction

  function automatic logic [15:0] exp_addr(input logic rom);
    return rom ? ROM_E : FLASH_E;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, MAX_CYC);
      finish_run();
    end
  end

  // One reset-and-boot sequence; the mode gives the detector history.
  task automatic boot_seq(input bit use_sw, input logic cfg, input int mode, input int gap,
                          input bit cfg_flip);
    logic rom_e;
    rom_e = exp_rom(cfg, mode);
    @(negedge clk);
    cfg_flash_boot = cfg;
    cyc_stb = 1'b0;
    hv_det = (mode == M_HELD || mode == M_DROP);
    if (use_sw) sw_rst = 1'b1; else rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 fetch_en in reset", fetch_en, 0);
    check(use_sw ? "R10 sel in sw reset" : "R1 sel in reset", boot_rom_sel, 0);
    check("R1 addr in reset", fetch_addr, FLASH_E);
    rst_n = 1'b1;
    sw_rst = 1'b0;
    if (mode == M_DROP) hv_det = 1'b0;
    if (mode == M_LATE) hv_det = 1'b1;
    if (cfg_flip) cfg_flash_boot = ~cfg; // R8: must not matter
    for (int s = 0; s < 3; s++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check("R2 held off", fetch_en, 0);
      end
      cyc_stb = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0;
      if (s < 2) check("R2 held off after strobe", fetch_en, 0);
    end
    check("R2 released", fetch_en, 1);
    case (mode)
      M_HELD:  check("R5 override", boot_rom_sel, rom_e);
      M_DROP:  check("R6 dropped override", boot_rom_sel, rom_e);
      M_LATE:  check("R7 late override", boot_rom_sel, rom_e);
      default: check(cfg ? "R4 flash boot" : "R3 rom boot", boot_rom_sel, rom_e);
    endcase
    check(cfg_flip ? "R8 addr" : "R3 addr", fetch_addr, exp_addr(rom_e));
    for (int k = 0; k < 12; k++) begin
      hv_det = 1'($urandom);
      cfg_flash_boot = 1'($urandom);
      cyc_stb = 1'($urandom);
      @(negedge clk);
    end
    cyc_stb = 1'b0;
    check("R9 fetch_en kept", fetch_en, 1);
    check("R9 sel kept", boot_rom_sel, rom_e);
    check("R9 addr kept", fetch_addr, exp_addr(rom_e));
  endtask

  initial begin
    void'($urandom(32'd1150));
    repeat (3) @(negedge clk);
    check("R1 power-up fetch_en", fetch_en, 0);
    // directed: every mode with both option values
    for (int m = 0; m < 4; m++) begin
      boot_seq(1'b0, 1'b0, m, 3, 1'b0);
      boot_seq(1'b0, 1'b1, m, 3, 1'b0);
    end
    // R8: option changed right after release
    boot_seq(1'b0, 1'b0, M_NONE, 4, 1'b1);
    boot_seq(1'b0, 1'b1, M_NONE, 4, 1'b1);
    // R10: software reset path
    boot_seq(1'b1, 1'b1, M_HELD, 3, 1'b0);
    boot_seq(1'b1, 1'b1, M_NONE, 5, 1'b1);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      boot_seq(1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
               int'($urandom_range(3, 7)), 1'($urandom));
    end
    finish_run();
  end
endmodule